// File: doc/BRIEF.md
# Result Descriptor Generator

The generator turns each finished packet into a result descriptor and writes it to a result ring in system memory. A packet arrives with the fields of its original descriptor and with what processing produced: an operation class, the next-header byte, the pad mode, the pad count, the output length and an error flag. Some fields are rewritten by fixed rules. The addresses and the security-association handle are copied unchanged.

Each input produces exactly one output entry, and this holds when processing ended in an error. The entry goes out as a single wide memory write with a valid/ready handshake. The write lands at the current ring slot, and the slot index wraps at the ring size. When memory stalls, the generator holds its entry and stops taking input. A running count of completed writes lets the surrounding logic check that it got as many results as it sent packets.

Top module: `rdesc_builder`

## Requirements
- R1: Every accepted input produces exactly one memory write, whatever the error flag, and `result_count` rises by one on each completed write (`wr_valid && wr_ready`) and at no other time.
- R2: The control byte (`wr_data[7:0]`) has bit 0 = 0 (host not done) and bit 1 = 1 (engine done). Bits 7:2 are copied from `in_ctrl`.
- R3: The next-header byte (`wr_data[15:8]`) equals `res_nh` when `res_op` is 1 (IPsec outbound) or 2 (IPsec inbound), and 0 for `res_op` 0 or 3.
- R4: The pad status byte (`wr_data[31:24]`) equals `res_pad_cnt` when `res_pad_mode` is 2 (IPsec) or 3 (PKCS #7), and 0 when it is 0 (zero pad) or 1 (constant pad).
- R5: Words 1, 2 and 3 (`wr_data[63:32]`, `[95:64]`, `[127:96]`) carry `in_src`, `in_dst` and `in_sa` unchanged.
- R6: `wr_data[143:128]` carries `res_len` and `wr_data[151:144]` is 0.
- R7: The status byte (`wr_data[23:16]`) has bit 0 = 1 (valid), bit 1 = `res_err` and the other bits 0. The control-2 byte (`wr_data[159:152]`) has bits 7:6 = 2'b10 (engine done), and bits 5:0 are copied from `in_ctl2`.
- R8: `wr_addr` = `RING_BASE + slot*ENTRY_BYTES`. The slot starts at 0 and steps by one per completed write, going back to 0 after `RING_ENTRIES-1`.
- R9: While `wr_valid` is high and `wr_ready` is low, `in_ready` is low and `wr_valid`, `wr_data` and `wr_addr` hold their values.
- R10: After reset `wr_valid` is 0, `in_ready` is 1, `result_count` is 0 and `wr_addr` equals `RING_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Finished packet presented |
| in_ready | output | 1 | Generator can take a packet |
| in_ctrl | input | 8 | Original control byte |
| in_src | input | 32 | Source address |
| in_dst | input | 32 | Destination address |
| in_sa | input | 32 | Security-association handle |
| in_ctl2 | input | 8 | Original control-2 byte |
| res_op | input | 2 | 0 other, 1 IPsec outbound, 2 IPsec inbound, 3 other |
| res_nh | input | 8 | Produced or extracted next-header byte |
| res_pad_mode | input | 2 | 0 zero, 1 constant, 2 IPsec, 3 PKCS #7 |
| res_pad_cnt | input | 8 | Pad bytes detected |
| res_len | input | 16 | Output length |
| res_err | input | 1 | Processing ended in error |
| wr_valid | output | 1 | Result write pending |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Ring slot byte address |
| wr_data | output | 160 | Assembled result descriptor, five 32-bit words |
| result_count | output | CNT_W | Completed result writes |

## Verification
The main sweep covers every combination of the four operation classes, the four pad modes and both error states, 32 packets in all, and each packet carries different field values. This separates the two IPsec directions from the other classes and the counting pad modes from the constant and zero modes. It also shows that errors neither drop a result nor change any field except the status bit. Each packet is held under a stall of 0 to 2 cycles before the write is accepted, and 32 writes wrap an 8-slot ring four times. A final back-to-back burst with memory always ready checks that the write count and the slot advance by one per cycle.

// File: rtl/rdesc_builder.sv
module rdesc_builder #(
  parameter int ADDR_W       = 32,
  parameter int RING_ENTRIES = 8,
  parameter int ENTRY_BYTES  = 32,
  parameter int CNT_W        = 16,
  parameter logic [ADDR_W-1:0] RING_BASE = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_ctrl,
  input  logic [31:0]       in_src,
  input  logic [31:0]       in_dst,
  input  logic [31:0]       in_sa,
  input  logic [7:0]        in_ctl2,
  input  logic [1:0]        res_op,
  input  logic [7:0]        res_nh,
  input  logic [1:0]        res_pad_mode,
  input  logic [7:0]        res_pad_cnt,
  input  logic [15:0]       res_len,
  input  logic              res_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [159:0]      wr_data,
  output logic [CNT_W-1:0]  result_count
);
  localparam int PTR_W = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(RING_ENTRIES - 1);

  logic [PTR_W-1:0] slot;
  logic             wr_done;
  logic             take;
  logic [7:0]       nh_out, pad_out;
  logic [159:0]     entry;

  assign wr_done  = wr_valid && wr_ready;
  assign in_ready = !wr_valid || wr_ready;
  assign take     = in_valid && in_ready;
  assign wr_addr  = RING_BASE + ADDR_W'(slot) * ADDR_W'(ENTRY_BYTES);

  assign nh_out  = (res_op == 2'd1 || res_op == 2'd2) ? res_nh : 8'h00;
  assign pad_out = res_pad_mode[1] ? res_pad_cnt : 8'h00;

  assign entry = {{2'b10, in_ctl2[5:0]}, 8'h00, res_len,
                  in_sa, in_dst, in_src,
                  pad_out, {6'b0, res_err, 1'b1}, nh_out, {in_ctrl[7:2], 2'b10}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid     <= 1'b0;
      wr_data      <= '0;
      slot         <= '0;
      result_count <= '0;
    end else begin
      if (take) begin
        wr_valid <= 1'b1;
        wr_data  <= entry;
      end else if (wr_done) begin
        wr_valid <= 1'b0;
      end
      if (wr_done) begin
        slot         <= (slot == LAST) ? '0 : slot + 1'b1;
        result_count <= result_count + 1'b1;
      end
    end
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> result_count == $past(result_count) + 1'b1);
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done |=> $stable(result_count));
  p_ctrl_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[1:0] == 2'b10);
  p_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[159:158] == 2'b10 && wr_data[16]));
  p_slot_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> slot == (($past(slot) == LAST) ? '0 : $past(slot) + 1'b1));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
  p_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !in_ready);
endmodule

// File: tb/rdesc_builder_bench.sv
module rdesc_builder_bench;
  localparam int N = 8;
  localparam int EB = 32;
  localparam logic [31:0] BASE = 32'h1000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, wr_valid, wr_ready = 0, res_err = 0;
  logic [7:0] in_ctrl = 0, in_ctl2 = 0, res_nh = 0, res_pad_cnt = 0;
  logic [31:0] in_src = 0, in_dst = 0, in_sa = 0, wr_addr;
  logic [1:0] res_op = 0, res_pad_mode = 0;
  logic [15:0] res_len = 0, result_count;
  logic [159:0] wr_data;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rdesc_builder #(.ADDR_W(32), .RING_ENTRIES(N), .ENTRY_BYTES(EB), .CNT_W(16), .RING_BASE(BASE))
  u_rdesc_builder (.*);

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [159:0] exp, held;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R10 valid", wr_valid, 0);
    chk("R10 ready", in_ready, 1);
    chk("R10 count", result_count, 0);
    chk("R10 addr", wr_addr, BASE);

    for (int i = 0; i < 32; i++) begin
      in_ctrl = 8'(i * 37 + 5); in_ctl2 = 8'(i * 11 + 3);
      in_src = 32'hA000_0000 + i * 7; in_dst = 32'hB000_0000 + i * 13;
      in_sa = 32'hC000_0000 + i * 19;
      res_op = 2'(i % 4); res_pad_mode = 2'((i / 4) % 4); res_err = 1'((i / 16) % 2);
      res_nh = 8'(50 + i); res_pad_cnt = 8'(i + 1); res_len = 16'(200 + i * 5);
      exp = {{2'b10, in_ctl2[5:0]}, 8'h00, res_len, in_sa, in_dst, in_src,
             (res_pad_mode >= 2) ? res_pad_cnt : 8'h00,
             {6'b0, res_err, 1'b1},
             (res_op == 1 || res_op == 2) ? res_nh : 8'h00,
             {in_ctrl[7:2], 2'b10}};
      in_valid = 1;
      @(posedge clk);
      @(negedge clk) in_valid = 0;
      chk("R1 valid", wr_valid, 1);
      chk("R2 ctrl", wr_data[7:0], exp[7:0]);
      chk("R3 nexthdr", wr_data[15:8], exp[15:8]);
      chk("R4 pad", wr_data[31:24], exp[31:24]);
      chk("R5 copy", wr_data[127:32], exp[127:32]);
      chk("R6 len", wr_data[151:128], exp[151:128]);
      chk("R7 status/ctl2", {wr_data[159:152], wr_data[23:16]}, {exp[159:152], exp[23:16]});
      chk("R8 addr", wr_addr, BASE + (i % N) * EB);
      held = wr_data;
      for (int k = 0; k < i % 3; k++) begin
        @(negedge clk);
        chk("R9 hold", {wr_valid, wr_data}, {1'b1, held});
        chk("R9 ready", in_ready, 0);
      end
      wr_ready = 1;
      @(posedge clk);
      @(negedge clk) wr_ready = 0;
      chk("R1 count", result_count, 16'(i + 1));
      chk("R1 drained", wr_valid, 0);
    end

    wr_ready = 1; in_valid = 1;
    repeat (6) @(posedge clk);
    @(negedge clk) in_valid = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 burst count", result_count, 38);
    chk("R8 burst addr", wr_addr, BASE + (38 % N) * EB);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule